// File: doc/BRIEF.md
# UART Loopback and Modem-Status Crossover

This block sits on the receive side of a UART control path and provides the internal self-test path. A control word sets the loop enable and the four modem control outputs. While looping, those outputs are copied onto the modem status flags, and the modem-status interrupt group is rebuilt from the new flags. Transmit writes and send-break assertions are steered straight into a small receive FIFO, and anything arriving from the external line is discarded. With looping off, the status flags follow the external modem inputs and the FIFO takes the external receive stream.

A two-state machine holds the operating mode. The states are `MODE_EXTERNAL` and `MODE_LOOPBACK`. The transition `ENTER_LOOP` is taken on a control write with the loop enable set while in `MODE_EXTERNAL`. The transition `LEAVE_LOOP` is taken on a control write with the loop enable clear while in `MODE_LOOPBACK`. Every other case holds the current state. A single-push-per-cycle source selector feeds the FIFO. The FIFO shows its head word ahead of the pop. Each word is DATA_W data bits plus a break flag in the top bit.

Top module: `uart_loopback_top`

## Requirements
- R1: After reset the mode is external, the modem flags and modem interrupt bits are all 0, and the receive FIFO is empty (rx_valid 0, rx_count 0).
- R2: A control write with loop enable set (ctrl_data bit 0) sets the ring flag (modem bit 3) from ctrl_data bit 4 and the carrier flag (modem bit 2) from ctrl_data bit 3. Both are visible on the next cycle.
- R3: On the same write, the clear-to-send flag (modem bit 0) takes ctrl_data bit 2 and the data-set-ready flag (modem bit 1) takes ctrl_data bit 1.
- R4: The mapping is applied by the very write that switches looping on, and by every later control write while looping. Between control writes the flags hold, whatever the external modem inputs do.
- R5: On each such write all four modem interrupt bits are cleared, then set for every flag that is high. Bits set by an earlier write are cleared if their flag is now low.
- R6: While looping, a transmit write places {break=0, tx_data} into the receive FIFO on the next cycle.
- R7: While looping, a line-control write that raises the send-break bit from 0 to 1 places a break word {break=1, data=0} into the FIFO. Writes that keep it at 1 or drop it to 0 push nothing.
- R8: While looping, external receive bytes and external break events push nothing.
- R9: While not looping, the modem flags follow ext_modem one cycle later, and control writes with loop enable clear leave them unchanged. Transmit writes push nothing. External bytes push {0, data}, and external break events push {1, 0}.
- R10: A push into a full FIFO is dropped. rx_count stays at FIFO_DEPTH and the stored words come out unchanged and in order.
- R11: At most one word is pushed per cycle, chosen in this priority order: loop break, loop transmit, external break, external data.
- R12: While not looping, the modem interrupt bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 5 | {out2, out1, rts, dtr, loop_en} |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_break | input | 1 | Send-break bit of the line-control write |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | DATA_W | Transmit data |
| ext_rx_valid | input | 1 | External received byte strobe |
| ext_rx_data | input | DATA_W | External received byte |
| ext_break | input | 1 | External break event strobe |
| ext_modem | input | 4 | External modem inputs {ri, dcd, dsr, cts} |
| rx_pop | input | 1 | Pop the FIFO head |
| rx_valid | output | 1 | FIFO not empty |
| rx_word | output | DATA_W+1 | FIFO head, break flag in the top bit |
| rx_count | output | CNT_W | FIFO occupancy |
| rx_full | output | 1 | FIFO full |
| loop_active | output | 1 | Mode is loopback |
| modem_flags | output | 4 | Modem status flags {ri, dcd, dsr, cts} |
| modem_irq | output | 4 | Modem interrupt bits, same order |

## Verification
The crossover is tried with one control output raised at a time, so that a swapped pair of flags shows up as the wrong single bit. An all-ones write followed by a single-bit write shows whether earlier interrupt bits are really cleared. Transmit words, repeated and falling break writes, and external traffic are sent in both modes, which separates the redirect path from the discard path. Simultaneous sources and overfill past the depth expose wrong priority and corrupted occupancy.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

    typedef struct packed {
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
        logic loop_en;
    } lb_ctrl_t;

    typedef enum logic {
        MODE_EXTERNAL = 1'b0,
        MODE_LOOPBACK = 1'b1
    } lb_mode_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LOOP_BRK,
        SRC_LOOP_TX,
        SRC_EXT_BRK,
        SRC_EXT_DATA
    } push_src_e;

    localparam int MS_CTS = 0;
    localparam int MS_DSR = 1;
    localparam int MS_DCD = 2;
    localparam int MS_RI  = 3;
    localparam int MS_W   = 4;

    function automatic logic [MS_W-1:0] crossover(input lb_ctrl_t c);
        logic [MS_W-1:0] m;
        m         = '0;
        m[MS_RI]  = c.out2;
        m[MS_DCD] = c.out1;
        m[MS_CTS] = c.rts;
        m[MS_DSR] = c.dtr;
        return m;
    endfunction

endpackage

// File: rtl/lb_mode_fsm.sv
module lb_mode_fsm
    import uart_lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ctrl_wr,
    input  lb_ctrl_t ctrl_data,
    output lb_mode_e mode
);

    lb_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_EXTERNAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_EXTERNAL: if (ctrl_wr && ctrl_data.loop_en)  state_d = MODE_LOOPBACK; // ENTER_LOOP
            MODE_LOOPBACK: if (ctrl_wr && !ctrl_data.loop_en) state_d = MODE_EXTERNAL; // LEAVE_LOOP
            default:       state_d = MODE_EXTERNAL;
        endcase
    end

    assign mode = state_q;

    assert_mode_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (mode == MODE_LOOPBACK) == $past(ctrl_data.loop_en));

endmodule

// File: rtl/lb_modem_map.sv
module lb_modem_map
    import uart_lb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  lb_mode_e        mode,
    input  logic            ctrl_wr,
    input  lb_ctrl_t        ctrl_data,
    input  logic [MS_W-1:0] ext_modem,
    output logic [MS_W-1:0] flags,
    output logic [MS_W-1:0] irq
);

    logic            loop_eff;
    logic [MS_W-1:0] mapped;
    logic [MS_W-1:0] irq_rebuilt;

    always_comb begin
        loop_eff = ctrl_wr ? ctrl_data.loop_en : (mode == MODE_LOOPBACK);
        mapped   = crossover(ctrl_data);
        // clear the whole group, then set one bit per high flag
        irq_rebuilt = '0;
        for (int i = 0; i < MS_W; i++) begin
            if (mapped[i]) irq_rebuilt[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            irq   <= '0;
        end else if (!loop_eff) begin
            flags <= ext_modem;
        end else if (ctrl_wr) begin
            flags <= mapped;
            irq   <= irq_rebuilt;
        end
    end

    assert_ri_dcd_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_data.loop_en) |=>
            (flags[MS_RI] == $past(ctrl_data.out2)) && (flags[MS_DCD] == $past(ctrl_data.out1)));

    assert_cts_dsr_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_data.loop_en) |=>
            (flags[MS_CTS] == $past(ctrl_data.rts)) && (flags[MS_DSR] == $past(ctrl_data.dtr)));

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOOPBACK && !ctrl_wr) |=> $stable(flags));

    assert_irq_matches_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_data.loop_en) |=> (irq == flags));

    assert_irq_hold_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr && ctrl_data.loop_en) && (mode == MODE_EXTERNAL) |=> $stable(irq));

endmodule

// File: rtl/lb_push_select.sv
module lb_push_select
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lb_mode_e          mode,
    input  logic              lcr_wr,
    input  logic              lcr_break,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_break,
    output logic              push,
    output logic [DATA_W:0]   push_word
);

    logic      brk_q;
    logic      brk_rise;
    push_src_e src;

    always_ff @(posedge clk) begin
        if (!rst_n)      brk_q <= 1'b0;
        else if (lcr_wr) brk_q <= lcr_break;
    end

    assign brk_rise = lcr_wr && lcr_break && !brk_q;

    always_comb begin
        src = SRC_NONE;
        if (mode == MODE_LOOPBACK) begin
            if (brk_rise)   src = SRC_LOOP_BRK;
            else if (tx_wr) src = SRC_LOOP_TX;
        end else begin
            if (ext_break)         src = SRC_EXT_BRK;
            else if (ext_rx_valid) src = SRC_EXT_DATA;
        end
    end

    always_comb begin
        push      = 1'b1;
        push_word = '0;
        unique case (src)
            SRC_LOOP_BRK, SRC_EXT_BRK: push_word = {1'b1, {DATA_W{1'b0}}};
            SRC_LOOP_TX:               push_word = {1'b0, tx_data};
            SRC_EXT_DATA:              push_word = {1'b0, ext_rx_data};
            default:                   push      = 1'b0;
        endcase
    end

    assert_break_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOOPBACK && brk_rise) |-> (push && push_word[DATA_W]));

    assert_tx_only_looped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EXTERNAL && tx_wr && !ext_rx_valid && !ext_break) |-> !push);

endmodule

// File: rtl/lb_rx_fifo.sv
module lb_rx_fifo #(
    parameter int WORD_W = 9,
    parameter int DEPTH  = 4,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == ADDR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == ADDR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == FULL_CNT));

endmodule

// File: rtl/uart_loopback_top.sv
module uart_loopback_top
    import uart_lb_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [4:0]        ctrl_data,
    input  logic              lcr_wr,
    input  logic              lcr_break,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_break,
    input  logic [3:0]        ext_modem,
    input  logic              rx_pop,
    output logic              rx_valid,
    output logic [DATA_W:0]   rx_word,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_full,
    output logic              loop_active,
    output logic [3:0]        modem_flags,
    output logic [3:0]        modem_irq
);

    lb_ctrl_t        ctrl_s;
    lb_mode_e        mode;
    logic            push;
    logic [DATA_W:0] push_word;
    logic            empty;

    assign ctrl_s      = lb_ctrl_t'(ctrl_data);
    assign loop_active = (mode == MODE_LOOPBACK);
    assign rx_valid    = !empty;

    lb_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (ctrl_s),
        .mode      (mode)
    );

    lb_modem_map u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (ctrl_s),
        .ext_modem (ext_modem),
        .flags     (modem_flags),
        .irq       (modem_irq)
    );

    lb_push_select #(.DATA_W(DATA_W)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .lcr_wr       (lcr_wr),
        .lcr_break    (lcr_break),
        .tx_wr        (tx_wr),
        .tx_data      (tx_data),
        .ext_rx_valid (ext_rx_valid),
        .ext_rx_data  (ext_rx_data),
        .ext_break    (ext_break),
        .push         (push),
        .push_word    (push_word)
    );

    lb_rx_fifo #(.WORD_W(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (rx_pop),
        .head      (rx_word),
        .count     (rx_count),
        .empty     (empty),
        .full      (rx_full)
    );

    assert_ext_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active && (ext_rx_valid || ext_break) && !tx_wr && !lcr_wr && !rx_pop)
            |=> $stable(rx_count));

    assert_tx_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_active && tx_wr && !lcr_wr && !rx_pop && !rx_full) |=> (rx_count == $past(rx_count) + 1'b1));

endmodule

// File: tb/uart_loopback_top_tb.sv
module uart_loopback_top_tb;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_wr = 1'b0;
    logic [4:0]        ctrl_data = '0;
    logic              lcr_wr = 1'b0;
    logic              lcr_break = 1'b0;
    logic              tx_wr = 1'b0;
    logic [DATA_W-1:0] tx_data = '0;
    logic              ext_rx_valid = 1'b0;
    logic [DATA_W-1:0] ext_rx_data = '0;
    logic              ext_break = 1'b0;
    logic [3:0]        ext_modem = '0;
    logic              rx_pop = 1'b0;
    logic              rx_valid;
    logic [DATA_W:0]   rx_word;
    logic [CNT_W-1:0]  rx_count;
    logic              rx_full;
    logic              loop_active;
    logic [3:0]        modem_flags;
    logic [3:0]        modem_irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DATA_W:0] expq [$];
    string cur_req = "R1";

    always #10 clk = ~clk;

    uart_loopback_top #(.DATA_W(DATA_W), .FIFO_DEPTH(DEPTH)) u_dut (.*);

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // monitor: compares each popped word against the scoreboard
    always @(posedge clk) begin
        if (rst_n && rx_pop && rx_valid) begin
            if (expq.size() == 0) check(1'b0, cur_req, "unexpected word", int'(rx_word), 0);
            else begin
                logic [DATA_W:0] e;
                e = expq.pop_front();
                check(rx_word == e, cur_req, "popped word", int'(rx_word), int'(e));
            end
        end
    end

    task automatic step();
        @(negedge clk);
        ctrl_wr = 0; lcr_wr = 0; tx_wr = 0; ext_rx_valid = 0; ext_break = 0; rx_pop = 0;
    endtask

    task automatic wr_ctrl(input logic [4:0] d);
        ctrl_wr = 1; ctrl_data = d; step();
    endtask

    task automatic send_tx(input logic [7:0] d, input bit expect_push);
        tx_wr = 1; tx_data = d;
        if (expect_push && expq.size() < DEPTH) expq.push_back({1'b0, d});
        step();
    endtask

    task automatic drain(input string req);
        cur_req = req;
        while (rx_valid) begin
            rx_pop = 1; step();
        end
        check(expq.size() == 0, req, "words left unseen", expq.size(), 0);
        check(rx_count == 0, req, "count after drain", int'(rx_count), 0);
        expq.delete();
    endtask

    initial begin
        #(20 * 5000);
        check(1'b0, "watchdog", "timeout", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset state
        check(!loop_active, "R1", "mode", loop_active, 0);
        check(modem_flags == 0 && modem_irq == 0, "R1", "flags/irq", {modem_flags, modem_irq}, 0);
        check(!rx_valid && rx_count == 0, "R1", "fifo empty", int'(rx_count), 0);

        // R9 external mode: flags follow inputs, ctrl writes without loop_en do not touch them
        ext_modem = 4'b1010; step();
        check(modem_flags == 4'b1010, "R9", "flags follow ext", modem_flags, 4'b1010);
        wr_ctrl(5'b11110);
        check(modem_flags == 4'b1010, "R9", "ctrl write no effect", modem_flags, 4'b1010);
        check(modem_irq == 0, "R12", "irq unchanged off", modem_irq, 0);
        send_tx(8'h33, 1'b0);
        check(rx_count == 0, "R9", "tx not looped", int'(rx_count), 0);
        ext_rx_valid = 1; ext_rx_data = 8'h41; expq.push_back({1'b0, 8'h41}); step();
        ext_break = 1; expq.push_back({1'b1, 8'h00}); step();
        check(rx_count == 2, "R9", "ext pushes", int'(rx_count), 2);
        drain("R9");

        // R4 the enabling write itself maps (all outputs low)
        wr_ctrl(5'b00001);
        check(loop_active, "R4", "mode on", loop_active, 1);
        check(modem_flags == 4'b0000, "R4", "map on enable write", modem_flags, 0);
        wr_ctrl(5'b10001);
        check(modem_flags == 4'b1000, "R2", "out2->ri", modem_flags, 4'b1000);
        wr_ctrl(5'b01001);
        check(modem_flags == 4'b0100, "R2", "out1->dcd", modem_flags, 4'b0100);
        wr_ctrl(5'b00101);
        check(modem_flags == 4'b0001, "R3", "rts->cts", modem_flags, 4'b0001);
        wr_ctrl(5'b00011);
        check(modem_flags == 4'b0010, "R3", "dtr->dsr", modem_flags, 4'b0010);
        wr_ctrl(5'b11111);
        check(modem_irq == 4'b1111, "R5", "irq all set", modem_irq, 4'b1111);
        wr_ctrl(5'b00101);
        check(modem_irq == 4'b0001, "R5", "irq old bits cleared", modem_irq, 4'b0001);
        ext_modem = 4'b0110; step(); step();
        check(modem_flags == 4'b0001, "R4", "flags hold", modem_flags, 4'b0001);

        // R6 R8 R7 looped data and break
        send_tx(8'h5A, 1'b1);
        check(rx_count == 1 && rx_word == {1'b0, 8'h5A}, "R6", "tx looped", int'(rx_word), 9'h05A);
        send_tx(8'hC3, 1'b1);
        ext_rx_valid = 1; ext_rx_data = 8'h77; step();
        ext_break = 1; step();
        check(rx_count == 2, "R8", "ext ignored", int'(rx_count), 2);
        lcr_wr = 1; lcr_break = 1; expq.push_back({1'b1, 8'h00}); step();
        lcr_wr = 1; lcr_break = 1; step();
        lcr_wr = 1; lcr_break = 0; step();
        check(rx_count == 3, "R7", "one break word", int'(rx_count), 3);
        drain("R7");

        // R11 loop break beats tx
        lcr_wr = 1; lcr_break = 1; tx_wr = 1; tx_data = 8'h99; expq.push_back({1'b1, 8'h00}); step();
        check(rx_count == 1, "R11", "single push", int'(rx_count), 1);
        drain("R11");
        lcr_wr = 1; lcr_break = 0; step();

        // R10 overfill
        for (int i = 0; i < DEPTH + 2; i++) send_tx(8'(8'h10 + i), 1'b1);
        check(rx_count == DEPTH && rx_full, "R10", "count saturates", int'(rx_count), DEPTH);
        drain("R10");

        // R9 R12 leave loopback
        wr_ctrl(5'b11110);
        check(!loop_active, "R9", "mode off", loop_active, 0);
        check(modem_flags == 4'b0110, "R9", "flags back to ext", modem_flags, 4'b0110);
        check(modem_irq == 4'b0001, "R12", "irq held", modem_irq, 4'b0001);
        ext_rx_valid = 1; ext_rx_data = 8'h55; ext_break = 1; expq.push_back({1'b1, 8'h00}); step();
        check(rx_count == 1, "R11", "ext break beats data", int'(rx_count), 1);
        drain("R11");

        finish_run();
    end

endmodule